// File: doc/BRIEF.md
# Differential Manchester Clock and Data Recovery

This block takes a differential Manchester line signal and rebuilds two things from it: a bit-rate clock and the data stream. It runs on a local system clock many times faster than the bit rate, and its nominal bit period is fixed by a parameter given in system-clock cycles. The line is first brought into the local clock domain through a flop chain. A transition detector then fires a one-cycle pulse on every change of level, whichever way it goes.

Only transitions at the centre of a bit cell may restart the recovered clock. Each accepted centre transition starts a half-bit timer, and the recovered clock is high while that timer runs. When the half-bit timer expires, a quarter-bit guard timer runs. Transitions that arrive while either timer is running are blanked: they are taken to be cell-boundary transitions. Each such blanked transition is remembered, and the next accepted centre transition reports it as a 1 on the data output, together with a one-cycle valid strobe.

A lock indicator shows when the centre transitions arrive at a credible rate. A consumer of the block waits for lock and then samples the data output on each strobe.

Top module: `mcr_clk_recover`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `rxc_o`, `rxd_o`, `rxd_vld_o` and `lock_o` are all 0.
- R2: The line passes through a two-flop synchronizer. For an accepted transition, `rxd_vld_o` is high for exactly one cycle: the cycle after the third rising clock edge that follows the change of `line_i`, counting the edge that first samples the new level.
- R3: Rising and falling transitions of the line are detected alike.
- R4: A transition that arrives while the recovered clock is high, or while the quarter-bit guard runs after it, produces no strobe. Each bit cell therefore yields exactly one strobe.
- R5: `rxc_o` rises in the same cycle as `rxd_vld_o` and stays high for exactly BIT_CYC/2 cycles.
- R6: The line code is as follows. Every bit cell has a transition at its centre. A 1 bit also has a transition at the start of its cell, and a 0 bit has none there. At each strobe, `rxd_o` is 1 if a blanked transition occurred since the previous accepted transition, and 0 otherwise. `rxd_o` changes only in strobe cycles.
- R7: `lock_o` becomes 1 when two successive accepted transitions are spaced between BIT_CYC - BIT_CYC/4 and BIT_CYC + BIT_CYC/4 cycles, inclusive. It becomes 0 when an accepted transition falls outside that window. It changes only in strobe cycles.
- R8: With BIT_CYC = 16, a transmitter bit period anywhere from 14 to 18 cycles decodes without error once lock is reached.
- R9: After reset the gate is open, so the first transition on the line is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Asynchronous differential Manchester line |
| rxc_o | output | 1 | Recovered bit clock, high for the half bit after each centre transition |
| rxd_o | output | 1 | Recovered data bit |
| rxd_vld_o | output | 1 | One-cycle strobe for each recovered bit |
| lock_o | output | 1 | Centre transitions are spaced within tolerance |

## Verification
The bench runs four sweeps: all zeros, all ones, alternating bits and a pseudo-random stream. It replays each sweep at every transmitter period from 14 to 18 cycles.

The all-ones stream puts a transition on the line every half bit. If the blanking window is too short, the block locks onto boundary transitions, and the bench sees doubled strobes and inverted data. The periods 14 and 18 drive the centre transition near the end of the guard window. An off-by-one in the guard timer or the half timer at these periods either drops a bit or accepts a boundary transition.

A run at 24 cycles, and a run that switches from 16 to 23 cycles part-way through, exercise the lock window. A design with a loose or one-sided tolerance check would keep `lock_o` high in these runs. The bench also counts the latency from each line change to its strobe. A synchronizer with a missing or extra stage shifts that latency by a cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    // lock tolerance is BIT_CYC >> TOL_SHIFT on either side of nominal
    localparam int unsigned TOL_SHIFT = 2;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/mcr_edge_sync.sv
module mcr_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] pipe;   // [SYNC_STAGES] is the previous synced level
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[SYNC_STAGES-1:0], line_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign edge_o = s_q.pipe[SYNC_STAGES] ^ s_q.pipe[SYNC_STAGES-1];
endmodule

// File: rtl/mcr_cell_timer.sv
module mcr_cell_timer #(
    parameter int unsigned HALF_CYC = 8,
    parameter int unsigned QTR_CYC  = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    output logic rxc_o,
    output logic blank_o
);
    localparam int unsigned HW = mcr_pkg::cnt_width(HALF_CYC);
    localparam int unsigned QW = mcr_pkg::cnt_width(QTR_CYC);

    typedef struct packed {
        logic [HW-1:0] half;
        logic [QW-1:0] qtr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig_i) begin
            s_d.half = HW'(HALF_CYC);
            s_d.qtr  = QW'(QTR_CYC);
        end else if (s_q.half != '0) begin
            s_d.half = s_q.half - 1'b1;
        end else if (s_q.qtr != '0) begin
            s_d.qtr = s_q.qtr - 1'b1;   // guard runs once the half timer has expired
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign rxc_o   = (s_q.half != '0);
    assign blank_o = rxc_o | (s_q.qtr != '0);
endmodule

// File: rtl/mcr_lock_mon.sv
module mcr_lock_mon #(
    parameter int unsigned BIT_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic accept_i,
    output logic lock_o
);
    localparam int unsigned TOL = BIT_CYC >> mcr_pkg::TOL_SHIFT;
    localparam int unsigned LO  = BIT_CYC - TOL;
    localparam int unsigned HI  = BIT_CYC + TOL;
    localparam int unsigned SAT = HI + 1;
    localparam int unsigned GW  = mcr_pkg::cnt_width(SAT);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic          seen;
        logic          lock;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.gap != GW'(SAT)) s_d.gap = s_q.gap + 1'b1;
        if (accept_i) begin
            s_d.gap  = GW'(1);
            s_d.seen = 1'b1;
            s_d.lock = s_q.seen && (s_q.gap >= GW'(LO)) && (s_q.gap <= GW'(HI));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign lock_o = s_q.lock;
endmodule

// File: rtl/mcr_clk_recover.sv
module mcr_clk_recover #(
    parameter int unsigned BIT_CYC     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    output logic rxc_o,
    output logic rxd_o,
    output logic rxd_vld_o,
    output logic lock_o
);
    localparam int unsigned HALF_CYC = BIT_CYC / 2;
    localparam int unsigned QTR_CYC  = BIT_CYC / 4;

    typedef struct packed {
        logic bnd;   // blanked transition seen since last accepted one
        logic rxd;
        logic vld;
    } state_t;

    state_t s_d, s_q;
    logic   edge_w, blank_w, accept_w, rxc_w;

    mcr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .line_i(line_i),
        .edge_o(edge_w)
    );

    // centre gate: edge AND not(recovered clock or guard)
    assign accept_w = edge_w & ~blank_w;

    mcr_cell_timer #(.HALF_CYC(HALF_CYC), .QTR_CYC(QTR_CYC)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .trig_i (accept_w),
        .rxc_o  (rxc_w),
        .blank_o(blank_w)
    );

    mcr_lock_mon #(.BIT_CYC(BIT_CYC)) u_lock (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .accept_i(accept_w),
        .lock_o  (lock_o)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (edge_w && blank_w) s_d.bnd = 1'b1;
        if (accept_w) begin
            s_d.rxd = s_q.bnd;
            s_d.bnd = 1'b0;
            s_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign rxc_o     = rxc_w;
    assign rxd_o     = s_q.rxd;
    assign rxd_vld_o = s_q.vld;
endmodule

// File: rtl/mcr_clk_recover_chk.sv
module mcr_clk_recover_chk #(
    parameter int unsigned BIT_CYC = 16
) (
    input logic clk_i,
    input logic rst_i,
    input logic rxc_o,
    input logic rxd_o,
    input logic rxd_vld_o,
    input logic lock_o
);
    localparam int unsigned HALF_CYC = BIT_CYC / 2;
    localparam int unsigned RW = mcr_pkg::cnt_width(HALF_CYC + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      run_q <= '0;
        else if (rxc_o) run_q <= (run_q == RW'(HALF_CYC + 1)) ? run_q : run_q + 1'b1;
        else            run_q <= '0;
    end

    p_vld_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        rxd_vld_o |=> !rxd_vld_o);

    p_vld_starts_rxc_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        rxd_vld_o |-> $rose(rxc_o));

    p_rxc_from_vld_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rxc_o) |-> rxd_vld_o);

    p_rxc_len_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        rxc_o |-> (run_q < RW'(HALF_CYC)));

    p_rxd_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !rxd_vld_o |-> $stable(rxd_o));

    p_lock_rise_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> rxd_vld_o);

    p_lock_fall_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(lock_o) |-> rxd_vld_o);
endmodule

bind mcr_clk_recover mcr_clk_recover_chk #(.BIT_CYC(BIT_CYC)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rxc_o    (rxc_o),
    .rxd_o    (rxd_o),
    .rxd_vld_o(rxd_vld_o),
    .lock_o   (lock_o)
);

// File: tb/mcr_clk_recover_bench.sv
module mcr_clk_recover_bench;
    localparam int BIT = 16;
    localparam int HALF = BIT / 2;
    localparam int PRE = 4;
    localparam int NBITS = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic rxc, rxd, vld, lock;

    always #10 clk = ~clk;   // 50 MHz

    mcr_clk_recover #(.BIT_CYC(BIT)) u_mcr_clk_recover (
        .clk_i    (clk),
        .rst_i    (rst),
        .line_i   (line),
        .rxc_o    (rxc),
        .rxd_o    (rxd),
        .rxd_vld_o(vld),
        .lock_o   (lock)
    );

    int n_chk = 0, n_fail = 0;     // main process
    int m_chk = 0, m_fail = 0;     // monitor process
    logic tx_bits [0:63];
    int vcount, cmp_cnt, run_len;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: data (R6), clock shape (R5)
    always @(negedge clk) begin
        if (rst) begin
            vcount = 0; cmp_cnt = 0; run_len = 0;
        end else begin
            if (vld) begin
                if (lock && vcount > 0) begin
                    m_chk++;
                    if (run_len != HALF) begin
                        m_fail++;
                        $display("FAIL R5 rxc high run actual=%0d expected=%0d", run_len, HALF);
                    end
                end
                m_chk++;
                if (!rxc) begin
                    m_fail++;
                    $display("FAIL R5 rxc at strobe actual=%0d expected=1", rxc);
                end
                if (lock && vcount < 64) begin
                    m_chk++;
                    cmp_cnt++;
                    if (rxd !== tx_bits[vcount]) begin
                        m_fail++;
                        $display("FAIL R6 bit %0d actual=%0d expected=%0d", vcount, rxd, tx_bits[vcount]);
                    end
                end
                vcount++;
                run_len = 1;
            end else if (rxc) begin
                run_len++;
            end
        end
    end

    // transmit one cell; checks strobe latency R2 and boundary blanking R4
    task automatic send_bit(input logic b, input int per);
        int h1, h2;
        h1 = per / 2;
        h2 = per - h1;
        if (b) line = ~line;
        for (int i = 0; i < h1; i++) begin
            @(negedge clk);
            if (i == 2 && b) check(vld == 1'b0, "R4 boundary blanked", vld, 0);
        end
        line = ~line;
        for (int i = 0; i < h2; i++) begin
            @(negedge clk);
            if (i == 2) check(vld == 1'b1, "R2 strobe latency", vld, 1);
            if (i == 3) check(vld == 1'b0, "R2 strobe width", vld, 0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line = 1'b0;
        repeat (3) @(negedge clk);
        check({rxc, rxd, vld, lock} == 4'b0, "R1 in reset", {rxc, rxd, vld, lock}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({rxc, rxd, vld, lock} == 4'b0, "R1 after reset", {rxc, rxd, vld, lock}, 0);
    endtask

    task automatic run_case(input int pat, input int per);
        logic [6:0] lf;
        lf = 7'(per * 5 + 1);
        for (int i = 0; i < 64; i++) tx_bits[i] = 1'b0;
        for (int i = PRE; i < NBITS; i++) begin
            case (pat)
                0: tx_bits[i] = 1'b0;
                1: tx_bits[i] = 1'b1;
                2: tx_bits[i] = logic'(i % 2);
                default: begin
                    lf = {lf[5:0], lf[6] ^ lf[5]};
                    tx_bits[i] = lf[0];
                end
            endcase
        end
        do_reset();
        for (int i = 0; i < NBITS; i++) send_bit(tx_bits[i], per);
        repeat (6) @(negedge clk);
        check(vcount == NBITS, "R4 R9 one strobe per cell", vcount, NBITS);
        if (per >= BIT - BIT / 4 && per <= BIT + BIT / 4) begin
            check(lock == 1'b1, "R7 R8 lock in tolerance", lock, 1);
            check(cmp_cnt == NBITS - 1, "R7 lock from second cell", cmp_cnt, NBITS - 1);
        end else begin
            check(lock == 1'b0, "R7 no lock out of tolerance", lock, 0);
            check(cmp_cnt == 0, "R7 no locked strobes", cmp_cnt, 0);
        end
    endtask

    initial begin
        for (int per = 14; per <= 18; per++)
            for (int pat = 0; pat < 4; pat++) run_case(pat, per);   // R3 R8 sweep
        run_case(0, 24);
        run_case(1, 24);
        // lock drop: in-tolerance then too slow
        for (int i = 0; i < 64; i++) tx_bits[i] = 1'b0;
        do_reset();
        for (int i = 0; i < 16; i++) send_bit(1'b0, 16);
        check(lock == 1'b1, "R7 lock before drop", lock, 1);
        for (int i = 0; i < 6; i++) send_bit(1'b0, 23);
        repeat (6) @(negedge clk);
        check(lock == 1'b0, "R7 lock after slow cells", lock, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk + 1, n_fail + m_fail + 1);
        $finish;
    end
endmodule